// File: doc/BRIEF.md
# Double-Buffered Endpoint Status Controller

This block keeps the per-endpoint bookkeeping a USB device needs between its packet engine and its processor. For each of sixteen endpoint slots (slot 0 is the control OUT endpoint, slot 1 the control IN endpoint, slots 2 to 15 the numbered endpoints 1 to 14) it tracks which of its packet buffers are occupied. It also tracks the stall state, the data toggle, and the state of any pending setup transfer.

The packet engine presents each finished packet or setup arrival for one cycle. In the same cycle it receives the handshake the link must return: ACK, NAK or STALL. The processor issues one-byte command codes. A clear code frees the buffer half the processor currently owns. A status code returns a snapshot byte of one slot on the cycle after the command. Stall set and clear, and setup acknowledge, arrive as simple strobes. A parameter mask chooses which slots have two buffer halves and which have one.

Top module: `ep_status_ctl`

## Requirements
- R1: After reset every status byte reads 0x00 for every slot.
- R2: A data packet to a free single-buffer slot is answered ACK (code 0) and sets the primary-full bit (bit 5). Every later data packet to that slot is answered NAK (code 1) until a clear command frees it.
- R3: Clear code 0x70 targets slot 0 and codes 0x72 to 0x7F target slots 2 to 15. Code 0x71 does nothing. A clear of slot 0 also drops the setup-held bit (bit 2).
- R4: A double-buffer slot fills its halves alternately, starting with the primary half. It answers NAK only while both halves are full, with secondary-full in bit 6.
- R5: A clear on a double-buffer slot empties the half selected for the processor and toggles the processor-select bit (bit 1). A clear whose selected half is empty changes nothing.
- R6: Code 0xD0+n returns the status byte of slot n with stat_valid one cycle later. The byte is {stalled, secondary full, primary full, data toggle, setup overwritten, setup held, processor select, 0}, MSB first. The read alters no bit other than the overwrite bit.
- R7: The data toggle (bit 4) flips on each ACKed data packet and is unchanged by a NAKed one.
- R8: A setup arrival on slot 0 is always answered ACK, even when the buffer is full. It sets the setup-held bit, the primary-full bit and a toggle of 1.
- R9: A setup arrival sets the overwrite bit (bit 3) when the previous setup was neither acknowledged nor followed by a stall of slot 0.
- R10: A status read of slot 0 clears the overwrite bit only after the setup-written strobe has marked the newest setup as complete. The byte returned is the value before the clear.
- R11: A stalled slot answers data packets with STALL (code 2) and shows bit 7. After a stall clear it answers normally again.
- R12: Every command other than a status read returns 0x00 with stat_valid. Undefined codes change no state.
- R13: On single-buffer slots the secondary-full and processor-select bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Packet engine presents a finished packet this cycle |
| lk_ep | input | EPW | Target slot of the packet |
| lk_setup | input | 1 | Packet is a setup arrival (effective on slot 0 only) |
| lk_setup_done | input | 1 | Newest setup data is completely written |
| lk_resp | output | 2 | Handshake for the presented packet: 0 ACK, 1 NAK, 2 STALL |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_code | input | 8 | Command code |
| stat_valid | output | 1 | Command result valid (one cycle after cmd_valid) |
| stat_data | output | 8 | Status byte, or 0x00 for non-read commands |
| stall_set | input | 1 | Set stall on slot stall_ep |
| stall_clr | input | 1 | Clear stall on slot stall_ep |
| stall_ep | input | EPW | Slot addressed by the stall strobes |
| setup_ack | input | 1 | Processor acknowledges the pending setup |

## Verification
The bench builds the block with a buffer mask in which only slot 3 has two halves. Slot 2 and slot 4 then show the single-buffer lock-out and the stall path. Slot 3 goes through the full alternation: fill both halves, NAK, clear each half in turn, and an idle clear that must have no effect. Slot 0 stays single-buffered and covers the overwrite sequence, including a read during an unfinished setup write.

// File: rtl/esc_pkg.sv
package esc_pkg;

   typedef enum logic [1:0] {
      HS_ACK   = 2'd0,
      HS_NAK   = 2'd1,
      HS_STALL = 2'd2
   } hs_e;

   // Status snapshot, MSB first; field order is visible to software.
   typedef struct packed {
      logic stalled;
      logic full_sec;
      logic full_pri;
      logic toggle;
      logic overwritten;
      logic setup_held;
      logic cpu_sel;
      logic rsvd;
   } ep_stat_t;

   localparam logic [3:0] GRP_CLEAR  = 4'h7;
   localparam logic [3:0] GRP_STATUS = 4'hD;
   localparam logic [3:0] CLR_HOLE   = 4'h1;

endpackage

// File: rtl/esc_cmd_decode.sv
module esc_cmd_decode
   import esc_pkg::*;
#(
   parameter int NUM_EP = 16,
   localparam int EPW   = $clog2(NUM_EP)
) (
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   output logic [NUM_EP-1:0] clr_vec,
   output logic [NUM_EP-1:0] rd_vec,
   output logic              rd_ok,
   output logic [EPW-1:0]    rd_idx
);

   logic [3:0] grp;
   logic [EPW-1:0] sel;

   assign grp = cmd_code[7:4];
   assign sel = cmd_code[EPW-1:0];

   always_comb begin
      clr_vec = '0;
      rd_vec  = '0;
      rd_ok   = 1'b0;
      rd_idx  = sel;
      if (cmd_valid) begin
         if (grp == GRP_CLEAR && cmd_code[3:0] != CLR_HOLE) begin
            clr_vec[sel] = 1'b1;
         end
         if (grp == GRP_STATUS) begin
            rd_vec[sel] = 1'b1;
            rd_ok       = 1'b1;
         end
      end
   end

endmodule

// File: rtl/esc_ep_slot.sv
module esc_ep_slot
   import esc_pkg::*;
#(
   parameter bit DOUBLE  = 1'b0,
   parameter bit CONTROL = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     lk_hit,
   input  logic     lk_setup,
   input  logic     setup_done,
   input  logic     clr_hit,
   input  logic     rd_hit,
   input  logic     stall_set,
   input  logic     stall_clr,
   input  logic     setup_ack,
   output hs_e      resp,
   output ep_stat_t stat
);

   logic       stall_q, tog_q, ovw_q, held_q, unack_q, busy_q;
   logic [1:0] full_q, full_d;
   logic       lp_q, cs_q;
   logic       su, accept, clr_do;

   // Setup arrivals only mean something on the control slot.
   assign su     = lk_hit & lk_setup & CONTROL;
   assign accept = lk_hit & ~su & ~stall_q & ~full_q[lp_q];
   assign clr_do = clr_hit & full_q[cs_q];

   generate
      if (DOUBLE) begin : g_dbl
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lp_q <= 1'b0;
               cs_q <= 1'b0;
            end else begin
               lp_q <= lp_q ^ accept;
               cs_q <= cs_q ^ clr_do;
            end
         end
      end else begin : g_sgl
         assign lp_q = 1'b0;
         assign cs_q = 1'b0;
      end
   endgenerate

   always_comb begin
      if (su)                resp = HS_ACK;
      else if (stall_q)      resp = HS_STALL;
      else if (full_q[lp_q]) resp = HS_NAK;
      else                   resp = HS_ACK;
   end

   always_comb begin
      full_d = full_q;
      if (clr_do) full_d[cs_q] = 1'b0;
      if (accept) full_d[lp_q] = 1'b1;
      if (su)     full_d[0]    = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall_q <= 1'b0;
         tog_q   <= 1'b0;
         ovw_q   <= 1'b0;
         held_q  <= 1'b0;
         unack_q <= 1'b0;
         busy_q  <= 1'b0;
         full_q  <= 2'b00;
      end else begin
         full_q <= full_d;
         if (stall_set)      stall_q <= 1'b1;
         else if (stall_clr) stall_q <= 1'b0;
         if (su)             tog_q <= 1'b1;
         else if (accept)    tog_q <= ~tog_q;
         if (su)             held_q <= 1'b1;
         else if (clr_hit)   held_q <= 1'b0;
         if (su)                          unack_q <= 1'b1;
         else if (setup_ack || stall_set) unack_q <= 1'b0;
         if (su)                          ovw_q <= ovw_q | unack_q;
         else if (rd_hit && !busy_q)      ovw_q <= 1'b0;
         if (su)              busy_q <= 1'b1;
         else if (setup_done) busy_q <= 1'b0;
      end
   end

   assign stat = '{stalled:     stall_q,
                   full_sec:    full_q[1],
                   full_pri:    full_q[0],
                   toggle:      tog_q,
                   overwritten: ovw_q,
                   setup_held:  held_q,
                   cpu_sel:     cs_q,
                   rsvd:        1'b0};

endmodule

// File: rtl/ep_status_ctl.sv
module ep_status_ctl
   import esc_pkg::*;
#(
   parameter int              NUM_EP   = 16,
   parameter logic [NUM_EP-1:0] DBL_MASK = 16'hFFF8,
   localparam int             EPW      = $clog2(NUM_EP)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           lk_valid,
   input  logic [EPW-1:0] lk_ep,
   input  logic           lk_setup,
   input  logic           lk_setup_done,
   output logic [1:0]     lk_resp,
   input  logic           cmd_valid,
   input  logic [7:0]     cmd_code,
   output logic           stat_valid,
   output logic [7:0]     stat_data,
   input  logic           stall_set,
   input  logic           stall_clr,
   input  logic [EPW-1:0] stall_ep,
   input  logic           setup_ack
);

   generate
      if (NUM_EP != 16) begin : g_bad_count
         $error("ep_status_ctl: the command map needs exactly 16 slots");
      end
      if (DBL_MASK[0]) begin : g_bad_ctrl
         $error("ep_status_ctl: the control OUT slot must be single-buffered");
      end
   endgenerate

   logic [NUM_EP-1:0]      clr_vec, rd_vec;
   logic                   rd_ok;
   logic [EPW-1:0]         rd_idx;
   hs_e  [NUM_EP-1:0]      resp_arr;
   logic [NUM_EP-1:0][7:0] ep_stat;

   esc_cmd_decode #(.NUM_EP(NUM_EP)) u_dec (
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .clr_vec   (clr_vec),
      .rd_vec    (rd_vec),
      .rd_ok     (rd_ok),
      .rd_idx    (rd_idx)
   );

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
         ep_stat_t st;
         esc_ep_slot #(
            .DOUBLE  (DBL_MASK[i]),
            .CONTROL (i == 0)
         ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .lk_hit     (lk_valid && lk_ep == EPW'(i)),
            .lk_setup   (lk_setup),
            .setup_done ((i == 0) && lk_setup_done),
            .clr_hit    (clr_vec[i]),
            .rd_hit     (rd_vec[i]),
            .stall_set  (stall_set && stall_ep == EPW'(i)),
            .stall_clr  (stall_clr && stall_ep == EPW'(i)),
            .setup_ack  ((i == 0) && setup_ack),
            .resp       (resp_arr[i]),
            .stat       (st)
         );
         assign ep_stat[i] = st;
      end
   endgenerate

   assign lk_resp = resp_arr[lk_ep];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_valid <= 1'b0;
         stat_data  <= 8'h00;
      end else begin
         stat_valid <= cmd_valid;
         stat_data  <= rd_ok ? ep_stat[rd_idx] : 8'h00;
      end
   end

endmodule

// File: rtl/ep_status_ctl_checker.sv
module ep_status_ctl_checker #(
   parameter int                NUM_EP   = 16,
   parameter logic [NUM_EP-1:0] DBL_MASK = 16'hFFF8,
   localparam int               EPW      = $clog2(NUM_EP)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   lk_valid,
   input logic [EPW-1:0]         lk_ep,
   input logic                   lk_setup,
   input logic [1:0]             lk_resp,
   input logic                   cmd_valid,
   input logic [7:0]             cmd_code,
   input logic                   stat_valid,
   input logic [7:0]             stat_data,
   input logic [NUM_EP-1:0][7:0] ep_stat
);

   logic su_now;
   assign su_now = lk_setup && lk_ep == '0;

   assert_nak_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && !su_now && !DBL_MASK[lk_ep] && !ep_stat[lk_ep][7] && ep_stat[lk_ep][5]
      |-> lk_resp == 2'd1);

   assert_nak_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && !su_now && DBL_MASK[lk_ep] && lk_resp == 2'd1
      |-> ep_stat[lk_ep][6] && ep_stat[lk_ep][5]);

   assert_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> stat_valid);

   assert_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> !stat_data[0]);

   assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && !su_now && lk_resp == 2'd0
      |=> ep_stat[$past(lk_ep)][4] != $past(ep_stat[lk_ep][4]));

   assert_setup_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && su_now |-> lk_resp == 2'd0);

   assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && !su_now && ep_stat[lk_ep][7] |-> lk_resp == 2'd2);

   assert_nonread_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_code[7:4] != 4'hD |=> stat_data == 8'h00);

   generate
      for (genvar i = 0; i < NUM_EP; i++) begin : g_sgl_chk
         if (!DBL_MASK[i]) begin : g_on
            assert_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
               !ep_stat[i][6] && !ep_stat[i][1]);
         end
      end
   endgenerate

endmodule

bind ep_status_ctl ep_status_ctl_checker #(
   .NUM_EP   (NUM_EP),
   .DBL_MASK (DBL_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_ep      (lk_ep),
   .lk_setup   (lk_setup),
   .lk_resp    (lk_resp),
   .cmd_valid  (cmd_valid),
   .cmd_code   (cmd_code),
   .stat_valid (stat_valid),
   .stat_data  (stat_data),
   .ep_stat    (ep_stat)
);

// File: tb/ep_status_ctl_test.sv
module ep_status_ctl_test;

   localparam int          NE   = 16;
   localparam logic [15:0] MASK = 16'h0008;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lk_valid = 1'b0, lk_setup = 1'b0, lk_setup_done = 1'b0;
   logic [3:0] lk_ep = '0, stall_ep = '0;
   logic [1:0] lk_resp;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_code = '0;
   logic       stat_valid;
   logic [7:0] stat_data;
   logic       stall_set = 1'b0, stall_clr = 1'b0, setup_ack = 1'b0;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   ep_status_ctl #(.NUM_EP(NE), .DBL_MASK(MASK)) uut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ep(lk_ep),
      .lk_setup(lk_setup), .lk_setup_done(lk_setup_done), .lk_resp(lk_resp),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .stat_valid(stat_valid),
      .stat_data(stat_data), .stall_set(stall_set), .stall_clr(stall_clr),
      .stall_ep(stall_ep), .setup_ack(setup_ack)
   );

   // Monitor: pops the scoreboard whenever a result appears.
   always @(negedge clk) begin
      if (rst_n && stat_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL unexpected result act=%02h exp=none", stat_data);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (stat_data !== e) begin
               fails++;
               $display("FAIL %s act=%02h exp=%02h", t, stat_data, e);
            end
         end
      end
   end

   task automatic cmd(input logic [7:0] code, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      cmd_valid = 1'b1;
      cmd_code  = code;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic rd(input int ep, input logic [7:0] exp, input string tag);
      cmd(8'hD0 | 8'(ep), exp, tag);
   endtask

   task automatic pkt(input int ep, input bit setup, input logic [1:0] exp, input string tag);
      lk_valid = 1'b1;
      lk_ep    = 4'(ep);
      lk_setup = setup;
      #1;
      checks++;
      if (lk_resp !== exp) begin
         fails++;
         $display("FAIL %s handshake act=%0d exp=%0d", tag, lk_resp, exp);
      end
      @(negedge clk);
      lk_valid = 1'b0;
      lk_setup = 1'b0;
   endtask

   task automatic strobe_stall(input int ep, input bit set);
      stall_ep  = 4'(ep);
      stall_set = set;
      stall_clr = !set;
      @(negedge clk);
      stall_set = 1'b0;
      stall_clr = 1'b0;
   endtask

   task automatic strobe_done();
      lk_setup_done = 1'b1;
      @(negedge clk);
      lk_setup_done = 1'b0;
   endtask

   task automatic strobe_ack();
      setup_ack = 1'b1;
      @(negedge clk);
      setup_ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: every slot reads zero after reset
      for (int i = 0; i < NE; i++) rd(i, 8'h00, "R1 reset");

      // R2, R7: single-buffer slot 2 locks after one packet
      pkt(2, 0, 2'd0, "R2 first packet");
      rd(2, 8'h30, "R2 R7 full and toggle");
      pkt(2, 0, 2'd1, "R2 locked");
      rd(2, 8'h30, "R7 NAK keeps toggle");

      // R12, R3: undefined codes
      cmd(8'h71, 8'h00, "R12 hole code");
      cmd(8'h45, 8'h00, "R12 foreign code");
      rd(2, 8'h30, "R3 R12 hole leaves slot 2");

      // R3, R13: clear slot 2
      cmd(8'h72, 8'h00, "R12 clear returns zero");
      rd(2, 8'h10, "R3 R13 slot 2 cleared");
      pkt(2, 0, 2'd0, "R2 accepted after clear");
      rd(2, 8'h20, "R7 toggle back");

      // R4, R5: double-buffer slot 3
      pkt(3, 0, 2'd0, "R4 primary fill");
      rd(3, 8'h30, "R4 primary full");
      pkt(3, 0, 2'd0, "R4 secondary fill");
      rd(3, 8'h60, "R4 both full");
      pkt(3, 0, 2'd1, "R4 both full NAK");
      rd(3, 8'h60, "R4 NAK no change");
      cmd(8'h73, 8'h00, "R5 clear cmd");
      rd(3, 8'h42, "R5 primary freed select 1");
      pkt(3, 0, 2'd0, "R4 refill primary");
      rd(3, 8'h72, "R4 refill");
      cmd(8'h73, 8'h00, "R5 clear cmd");
      rd(3, 8'h30, "R5 secondary freed select 0");
      cmd(8'h73, 8'h00, "R5 clear cmd");
      rd(3, 8'h12, "R5 primary freed select 1");
      cmd(8'h73, 8'h00, "R5 idle clear cmd");
      rd(3, 8'h12, "R5 idle clear no effect");

      // R11: stall on slot 4
      strobe_stall(4, 1'b1);
      pkt(4, 0, 2'd2, "R11 stalled");
      rd(4, 8'h80, "R11 stall bit");
      strobe_stall(4, 1'b0);
      pkt(4, 0, 2'd0, "R11 after clear");
      rd(4, 8'h30, "R11 normal again");

      // R8, R9, R10: setup handling on slot 0
      pkt(0, 0, 2'd0, "R2 control data");
      rd(0, 8'h30, "R2 control full");
      pkt(0, 1, 2'd0, "R8 setup into full buffer");
      rd(0, 8'h34, "R8 setup held toggle 1");
      pkt(0, 1, 2'd0, "R8 second setup");
      rd(0, 8'h3C, "R9 overwrite set");
      rd(0, 8'h3C, "R10 kept while writing");
      strobe_done();
      rd(0, 8'h3C, "R10 read returns old value");
      rd(0, 8'h34, "R10 overwrite cleared");
      strobe_ack();
      pkt(0, 1, 2'd0, "R8 setup after ack");
      rd(0, 8'h34, "R9 no overwrite after ack");
      strobe_done();
      pkt(0, 0, 2'd1, "R2 control locked");
      cmd(8'h70, 8'h00, "R3 control clear");
      rd(0, 8'h10, "R3 control cleared");
      cmd(8'hDF, 8'h00, "R6 slot 15 untouched");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R6 missing results act=%0d exp=0", exp_q.size());
      end
      finish_run();
   end

endmodule